// File: doc/BRIEF.md
# Eighth-Turn Complex Rotation Stage

This block rotates one complex sample per cycle by one of four fixed angles: no rotation, a quarter turn clockwise (multiply by -j), an eighth turn clockwise (multiply by (1 - j)/sqrt(2)) or three eighths of a turn clockwise (multiply by (-1 - j)/sqrt(2)). It sits inside a pipelined radix-2 transform stage, where the eighth-turn factors appear, and it needs no general multiplier and no coefficient table.

The sample first passes through an optional -j swap. A two-point butterfly then forms the sum and the difference of the real and imaginary parts. Both butterfly outputs are scaled by about 0.70703, and this scaling uses only shifts and adds built from the factored constant 1 + (1 + 1/4)(1/64 - 1/4). The three-eighths case reuses the same butterfly and the same single pair of scalers, with the -j swap placed in front. The scaler carries fractional guard bits and rounds once, to nearest, at its output. Outputs are one bit wider than inputs, so the most negative input can be negated or summed without wrap.

Top module: `rot8_top`

## Requirements
- R1: During reset and in the first cycle after it, outValid is 0 and outRe and outIm are 0.
- R2: A sample accepted with inValid high at clock edge k appears with outValid high after edge k+2. outValid is low after edge k+2 when inValid was low at edge k.
- R3: inSel = 2'b00 passes the sample unchanged: outRe = inRe and outIm = inIm, sign-extended to DATA_W+1 bits.
- R4: inSel = 2'b01 multiplies by -j exactly: outRe = inIm and outIm = -inRe. With inRe = -2^(DATA_W-1) the result is +2^(DATA_W-1), with no wrap.
- R5: inSel = 2'b10 multiplies by (1 - j)/sqrt(2): outRe = (inRe + inIm)/sqrt(2) and outIm = (inIm - inRe)/sqrt(2), each within 2 LSB.
- R6: inSel = 2'b11 multiplies by (-1 - j)/sqrt(2): outRe = (inIm - inRe)/sqrt(2) and outIm = -(inRe + inIm)/sqrt(2), each within 2 LSB.
- R7: Full-scale inputs never overflow a scaled result. For both scaled modes, |outRe| and |outIm| stay at or below 0.70703 * 2^DATA_W + 1.
- R8: While inValid is low, changes on inRe, inIm and inSel have no effect. outRe and outIm keep the last result and outValid stays 0.
- R9: Samples may arrive on consecutive cycles, each with a different inSel. Each sample's result depends only on its own data and select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sample on inRe/inIm/inSel is to be processed |
| inSel | input | 2 | Rotation: 00 none, 01 by -j, 10 by (1-j)/sqrt(2), 11 by (-1-j)/sqrt(2) |
| inRe | input | DATA_W | Real part of the input, two's complement |
| inIm | input | DATA_W | Imaginary part of the input, two's complement |
| outValid | output | 1 | outRe/outIm hold a new result |
| outRe | output | DATA_W+1 | Real part of the rotated sample |
| outIm | output | DATA_W+1 | Imaginary part of the rotated sample |

## Verification
The assertions assume that inSel and the data are meaningful only in cycles where inValid is high. They also assume that reset is held for at least two edges, so that the two-stage valid pipe starts empty. The stimulus changes data and select only at the falling edge. While inValid is low it deliberately drives unrelated values, which exercises the hold behaviour without ever presenting a value that would be treated as valid. The data stays inside the signed DATA_W range, and this range includes both extremes, where the growth bit and the scaled bound are under stress.

// File: rtl/rot8_pkg.sv
package rot8_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic ldStage1;  // capture input into stage 1
    logic swapJ;     // apply -j before the butterfly
    logic doBfly;    // stage 1 stores butterfly sum/difference
    logic ldStage2;  // capture stage 1 into the output registers
    logic useScale;  // output takes the scaled value
  } rotCtl_t;
endpackage

// File: rtl/rot8_scale.sv
// Fixed 1/sqrt(2) scaler: y = x * [1 + (1 + 2^-2)(2^-6 - 2^-2)], with guard bits and one rounding step
module rot8_scale #(
  parameter int IN_W    = 14,
  parameter int GUARD_W = 6,
  parameter int OUT_W   = 13
) (
  input  logic signed [IN_W-1:0]  x,
  output logic signed [OUT_W-1:0] y
);
  localparam int EXT_W = IN_W + GUARD_W + 1;
  localparam logic signed [EXT_W-1:0] HALF = EXT_W'(1) <<< (GUARD_W - 1);

  logic signed [EXT_W-1:0] xg, t1, t2, yg, rnd;
  logic unusedBits;

  assign xg  = {x[IN_W-1], x, {GUARD_W{1'b0}}};
  assign t1  = xg + (xg >>> 2);           // add 1, shift 1
  assign t2  = (t1 >>> 6) - (t1 >>> 2);   // add 2, shifts 2 and 3
  assign yg  = xg + t2;                   // add 3
  assign rnd = yg + HALF;
  assign y   = rnd[GUARD_W +: OUT_W];
  assign unusedBits = ^{rnd[GUARD_W-1:0], rnd[EXT_W-1:GUARD_W+OUT_W]};
endmodule

// File: rtl/rot8_ctrl.sv
module rot8_ctrl
  import rot8_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inSel,
  output rotCtl_t    ctl,
  output logic       outValid
);
  logic vS1, scaleS1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vS1      <= 1'b0;
      scaleS1  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      vS1      <= inValid;
      outValid <= vS1;
      if (inValid) scaleS1 <= inSel[1];
    end
  end

  always_comb begin
    ctl.ldStage1 = inValid;
    ctl.swapJ    = inSel[0];
    ctl.doBfly   = inSel[1];
    ctl.ldStage2 = vS1;
    ctl.useScale = scaleS1;
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);
endmodule

// File: rtl/rot8_datapath.sv
module rot8_datapath
  import rot8_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int GUARD_W = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rotCtl_t                  ctl,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  output logic signed [DATA_W:0]   outRe,
  output logic signed [DATA_W:0]   outIm
);
  localparam int ROT_W = DATA_W + 1;
  localparam int BF_W  = DATA_W + 2;
  localparam int LIM   = ((1 << DATA_W) * 181) / 256 + 1;

  logic signed [ROT_W-1:0] pRe, pIm;
  logic signed [BF_W-1:0]  sumV, difV;
  logic signed [BF_W-1:0]  s1Lane [2];
  logic signed [ROT_W-1:0] scLane [2];

  // optional -j rotation ahead of the butterfly
  always_comb begin
    if (ctl.swapJ) begin
      pRe = ROT_W'(inIm);
      pIm = -ROT_W'(inRe);
    end else begin
      pRe = ROT_W'(inRe);
      pIm = ROT_W'(inIm);
    end
    sumV = BF_W'(pRe) + BF_W'(pIm);
    difV = BF_W'(pIm) - BF_W'(pRe);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Lane[0] <= '0;
      s1Lane[1] <= '0;
    end else if (ctl.ldStage1) begin
      s1Lane[0] <= ctl.doBfly ? sumV : BF_W'(pRe);
      s1Lane[1] <= ctl.doBfly ? difV : BF_W'(pIm);
    end
  end

  // one scaler per lane, shared by both eighth-turn modes
  for (genvar g = 0; g < 2; g++) begin : gLane
    rot8_scale #(.IN_W(BF_W), .GUARD_W(GUARD_W), .OUT_W(ROT_W)) uScale (
      .x(s1Lane[g]),
      .y(scLane[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outRe <= '0;
      outIm <= '0;
    end else if (ctl.ldStage2) begin
      outRe <= ctl.useScale ? scLane[0] : s1Lane[0][ROT_W-1:0];
      outIm <= ctl.useScale ? scLane[1] : s1Lane[1][ROT_W-1:0];
    end
  end

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.ldStage2 |=> ($stable(outRe) && $stable(outIm)));
  // R7
  scaled_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ldStage2 && ctl.useScale) |=>
      (outRe <= LIM && outRe >= -LIM && outIm <= LIM && outIm >= -LIM));
endmodule

// File: rtl/rot8_top.sv
module rot8_top
  import rot8_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int GUARD_W = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [1:0]               inSel,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  output logic                     outValid,
  output logic signed [DATA_W:0]   outRe,
  output logic signed [DATA_W:0]   outIm
);
  rotCtl_t ctl;

  rot8_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSel(inSel),
    .ctl(ctl), .outValid(outValid)
  );

  rot8_datapath #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inRe(inRe), .inIm(inIm),
    .outRe(outRe), .outIm(outIm)
  );

  // R3
  pass_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSel == 2'b00) |-> ##2
      (outRe == $past(inRe, 2) && outIm == $past(inIm, 2)));
  // R4
  neg_j_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSel == 2'b01) |-> ##2
      (outRe == $past(inIm, 2) && (outIm + $past(inRe, 2)) == 0));
endmodule

// File: tb/sim_rot8_top.sv
`timescale 1ns/1ps
module sim_rot8_top;
  localparam int W = 12;
  localparam real K = 0.7071067811865476;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] inSel = 2'b00;
  logic signed [W-1:0] inRe = '0, inIm = '0;
  logic outValid;
  logic signed [W:0] outRe, outIm;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  rot8_top #(.DATA_W(W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSel(inSel),
    .inRe(inRe), .inIm(inIm), .outValid(outValid), .outRe(outRe), .outIm(outIm)
  );

  task automatic checkExact(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkNear(string tag, int act, real exp);
    real d;
    nChecks++;
    d = real'(act) - exp;
    if (d < 0.0) d = -d;
    if (d > 2.0) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %f", tag, act, exp);
    end
  endtask

  // reference rotation, independent of the hardware form
  task automatic checkResult(string tag, int a, int b, logic [1:0] s);
    int ar, ai;
    ar = int'(outRe);
    ai = int'(outIm);
    checkExact({tag, " valid"}, int'(outValid), 1);
    case (s)
      2'b00: begin checkExact({tag, " R3 re"}, ar, a); checkExact({tag, " R3 im"}, ai, b); end
      2'b01: begin checkExact({tag, " R4 re"}, ar, b); checkExact({tag, " R4 im"}, ai, -a); end
      2'b10: begin
        checkNear({tag, " R5 re"}, ar, real'(a + b) * K);
        checkNear({tag, " R5 im"}, ai, real'(b - a) * K);
      end
      default: begin
        checkNear({tag, " R6 re"}, ar, real'(b - a) * K);
        checkNear({tag, " R6 im"}, ai, -real'(a + b) * K);
      end
    endcase
  endtask

  task automatic runOne(string tag, int a, int b, logic [1:0] s);
    @(negedge clk);
    inValid = 1'b1; inSel = s; inRe = W'(a); inIm = W'(b);
    @(negedge clk);
    inValid = 1'b0; inRe = '0; inIm = '0; inSel = 2'b00;
    @(negedge clk);
    checkResult(tag, a, b, s);
  endtask

  task automatic testReset();
    // R1
    checkExact("R1 valid in reset", int'(outValid), 0);
    checkExact("R1 re in reset", int'(outRe), 0);
    checkExact("R1 im in reset", int'(outIm), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkExact("R1 valid after reset", int'(outValid), 0);
    checkExact("R1 re after reset", int'(outRe), 0);
  endtask

  task automatic testModes();
    runOne("pass", 1234, -567, 2'b00);
    runOne("negj", 300, -1500, 2'b01);
    runOne("w8", 1000, 200, 2'b10);
    runOne("w8b", -777, 1999, 2'b10);
    runOne("w3", 1000, 200, 2'b11);
    runOne("w3b", -1600, -900, 2'b11);
  endtask

  task automatic testExtremes();
    // R4 most negative input negates without wrap
    runOne("negj min", -2048, 2047, 2'b01);
    // R7 full scale in both scaled modes
    runOne("R7 w8 min", -2048, -2048, 2'b10);
    runOne("R7 w8 max", 2047, 2047, 2'b10);
    runOne("R7 w3 min", -2048, -2048, 2'b11);
    runOne("R7 w3 mix", 2047, -2048, 2'b11);
    runOne("pass min", -2048, -2048, 2'b00);
  endtask

  task automatic testLatency();
    // R2: valid two edges after acceptance, not one
    @(negedge clk);
    inValid = 1'b1; inSel = 2'b00; inRe = 12'sd5; inIm = 12'sd6;
    @(negedge clk);
    inValid = 1'b0;
    checkExact("R2 valid after one edge", int'(outValid), 0);
    @(negedge clk);
    checkExact("R2 valid after two edges", int'(outValid), 1);
    @(negedge clk);
    checkExact("R2 valid drops", int'(outValid), 0);
  endtask

  task automatic testIdle();
    int keepRe, keepIm;
    runOne("pre idle", 400, -100, 2'b10);
    keepRe = int'(outRe);
    keepIm = int'(outIm);
    // R8: junk on data and select while not valid
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      inValid = 1'b0; inSel = 2'(i); inRe = W'(i * 311 - 900); inIm = W'(1500 - i * 97);
    end
    @(negedge clk);
    @(negedge clk);
    checkExact("R8 valid idle", int'(outValid), 0);
    checkExact("R8 re held", int'(outRe), keepRe);
    checkExact("R8 im held", int'(outIm), keepIm);
  endtask

  task automatic testStream();
    int aV [4] = '{700, -1200, 2047, -333};
    int bV [4] = '{-50, 900, -2048, 1777};
    logic [1:0] sV [4] = '{2'b10, 2'b01, 2'b11, 2'b00};
    // R9: back-to-back samples with varying select
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 2) checkResult("R9 stream", aV[i-2], bV[i-2], sV[i-2]);
      if (i < 4) begin
        inValid = 1'b1; inSel = sV[i]; inRe = W'(aV[i]); inIm = W'(bV[i]);
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    checkExact("R9 stream end", int'(outValid), 0);
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    testReset();
    testModes();
    testExtremes();
    testLatency();
    testIdle();
    testStream();
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule